// File: doc/BRIEF.md
# PIO Request Address Region Classifier

This block watches the request bus that carries 130-bit packets from the processor toward the IO subsystem. It picks out two kinds of traffic by address. Writes to a small local register space program three address windows: a shared configuration/IO window, a 32-bit memory window and a 64-bit memory window. Requests aimed at the programmed-IO space are decoded into direction, transfer length, thread tag and address. The block then matches them against the enabled windows and reports one classified command per request.

Each window has a base register, whose top bit is its enable, and a mask register. A window matches when the masked address slice equals the base slice. The configuration/IO window compares a narrower slice than the memory windows. Inside it, one address bit separates IO from configuration accesses, and an address byte separates configuration type 0 from type 1. When several windows match, the 64-bit memory window wins over the 32-bit one, and the 32-bit one wins over configuration/IO. A request that matches no enabled window raises a separate unmatched flag. Downstream logic uses the classified command to build the matching bus transaction.

Top module: `pio_region_classifier`

## Requirements
- R1: The packet is captured on the clock edge that follows the edge at which `req_vld_i` is seen high. Packet contents present during the valid cycle itself are not used. The result appears on the outputs after that capture edge and stays for exactly one cycle.
- R2: Packet address bits 39:36 equal to 4'hC mark a request to classify. Address bits 39:32 equal to 8'h80 mark a local window-register access. Any other address, including 8'h88 in bits 39:32, produces no output and changes no window.
- R3: Packet bits 128:124 hold the request type, and 5'b00000 means read. For a read, the size field (bits 111:104) codes 0..4 give lengths 1, 2, 4, 8 and 16, and any other code gives 0. For a write, the size byte is passed through unchanged as a byte mask.
- R4: A local write updates a register when the low 16 address bits select it. 0x2000 and 0x2008 are the 32-bit memory base and mask. 0x2010 and 0x2018 are the 64-bit memory base and mask. 0x2020 and 0x2028 are the configuration/IO base and mask. The data is taken from packet bits 63:0. Local reads, and writes to other offsets, change nothing.
- R5: A memory window matches when its enable (base data bit 63) is set and (mask & address) equals base over address bits 35:24.
- R6: The configuration/IO window uses the same rule over address bits 35:29. Inside it, address bit 28 set means IO, and clear means configuration. A configuration access is type 0 when address bits 27:20 are all zero, and type 1 otherwise.
- R7: When windows overlap, the 64-bit memory window has the highest priority, then the 32-bit memory window, then configuration/IO.
- R8: A request to classify that matches no enabled window pulses `cmd_miss_o` instead of `cmd_vld_o`. A disabled window never matches. The two flags are never high together.
- R9: `cmd_code_o` = 2*kind + write. The kind values are: configuration type 0 = 0, configuration type 1 = 1, IO = 2, 32-bit memory = 3, 64-bit memory = 4. This gives codes 0..9, and the code is 0 on a miss. Address, length, thread tag (packet bits 122:117) and write data are carried with both flags.
- R10: Reset clears all window registers, which disables every window, and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request valid; the packet follows one cycle later |
| req_pkt_i | input | 130 | Request packet |
| cmd_vld_o | output | 1 | Classified command valid, one cycle |
| cmd_miss_o | output | 1 | Request matched no enabled window, one cycle |
| cmd_code_o | output | 4 | Command code (R9) |
| cmd_addr_o | output | 40 | Request address |
| cmd_len_o | output | 8 | Read length in bytes or write byte mask |
| cmd_tid_o | output | 6 | Thread tag |
| cmd_data_o | output | 64 | Write data |

## Verification
On every cycle, the assertions check the following: the valid and unmatched flags are exclusive; every result traces back to a valid input two cycles earlier; codes stay in range; read lengths are legal sizes; IO and type-0 codes agree with their address bits; a 64-bit memory match always wins; and the window enables stay frozen without a local write and come up clear after reset. Only the bench's scenarios can show that the windows decode their offsets correctly, that mask and base values produce the intended hits and misses, and that overlap priority holds against the lower windows. The same scenarios check that disabling a window, local reads and the foreign register space have no effect, and that the packet seen during the valid cycle is ignored.

// File: rtl/pio_cls_pkg.sv
package pio_cls_pkg;

    // packet field positions
    localparam int PKT_W     = 130;
    localparam int RQ_HI     = 128;
    localparam int RQ_LO     = 124;
    localparam int TID_HI    = 122;
    localparam int TID_LO    = 117;
    localparam int SIZE_HI   = 111;
    localparam int SIZE_LO   = 104;
    localparam int ADDR_HI   = 103;
    localparam int ADDR_LO   = 64;
    localparam int DATA_HI   = 63;

    localparam int ADDR_W    = ADDR_HI - ADDR_LO + 1;
    localparam int DATA_W    = DATA_HI + 1;
    localparam int TID_W     = TID_HI - TID_LO + 1;
    localparam int SIZE_W    = SIZE_HI - SIZE_LO + 1;
    localparam int RQ_W      = RQ_HI - RQ_LO + 1;

    // address comparison slice
    localparam int CMP_HI    = 35;
    localparam int MEM_LO    = 24;
    localparam int CFG_LO    = 29;
    localparam int CMP_W     = CMP_HI - MEM_LO + 1;
    localparam int IO_BIT    = 28;
    localparam int BUS_HI    = 27;
    localparam int BUS_LO    = 20;
    localparam int EN_BIT    = 63;

    // windows, listed in evaluation order (later wins)
    localparam int NWIN      = 3;
    localparam int WIN_CFG   = 0;
    localparam int WIN_M32   = 1;
    localparam int WIN_M64   = 2;
    localparam int MAX_RDSZ  = 4;

    typedef enum logic [2:0] {
        K_CFG0  = 3'd0,
        K_CFG1  = 3'd1,
        K_IO    = 3'd2,
        K_MEM32 = 3'd3,
        K_MEM64 = 3'd4
    } kind_e;

    typedef struct packed {
        logic              rd;
        logic [TID_W-1:0]  tid;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    typedef struct packed {
        logic              vld;
        logic              miss;
        logic [3:0]        code;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] len;
        logic [TID_W-1:0]  tid;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic             en;
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
    } win_t;

endpackage

// File: rtl/pio_pkt_decode.sv
module pio_pkt_decode
    import pio_cls_pkg::*;
#(
    parameter logic [3:0] PIO_TAG   = 4'hC,
    parameter logic [7:0] LOCAL_TAG = 8'h80
) (
    input  logic [PKT_W-1:0] pkt_i,
    output req_t             req_o,
    output logic             is_pio_o,
    output logic             is_local_o
);

    logic pkt_unused;
    assign pkt_unused = ^{pkt_i[PKT_W-1], pkt_i[RQ_LO-1], pkt_i[TID_LO-1:SIZE_HI+1]};

    always_comb begin
        req_o.rd   = (pkt_i[RQ_HI:RQ_LO] == '0);
        req_o.tid  = pkt_i[TID_HI:TID_LO];
        req_o.size = pkt_i[SIZE_HI:SIZE_LO];
        req_o.addr = pkt_i[ADDR_HI:ADDR_LO];
        req_o.data = pkt_i[DATA_HI:0];
        is_pio_o   = (pkt_i[ADDR_HI -: 4] == PIO_TAG);
        is_local_o = (pkt_i[ADDR_HI -: 8] == LOCAL_TAG);
    end

endmodule

// File: rtl/pio_window_bank.sv
module pio_window_bank
    import pio_cls_pkg::*;
#(
    parameter logic [15:0] LOCAL_OFS = 16'h2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [15:0]      wr_ofs_i,
    input  logic             wr_enbit_i,
    input  logic [CMP_W-1:0] wr_field_i,
    input  logic [CMP_W-1:0] cmp_addr_i,
    output logic [NWIN-1:0]  win_en_o,
    output logic [NWIN-1:0]  match_o
);

    logic [2:0] slot;
    logic       ofs_hit;
    logic       is_mask;
    logic [1:0] tgt;

    always_comb begin
        slot    = wr_ofs_i[5:3];
        is_mask = slot[0];
        ofs_hit = wr_en_i
               && (wr_ofs_i[15:6] == LOCAL_OFS[15:6])
               && (wr_ofs_i[2:0] == 3'd0)
               && (slot <= 3'd5);
        case (slot[2:1])
            2'd0:    tgt = 2'(WIN_M32);
            2'd1:    tgt = 2'(WIN_M64);
            default: tgt = 2'(WIN_CFG);
        endcase
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int LO = (g == WIN_CFG) ? CFG_LO : MEM_LO;
        localparam logic [CMP_W-1:0] CARE = {CMP_W{1'b1}} << (LO - MEM_LO);

        win_t w_d;
        win_t w_q;

        always_comb begin
            w_d = w_q;
            if (ofs_hit && (tgt == 2'(g))) begin
                if (is_mask) begin
                    w_d.mask = wr_field_i;
                end else begin
                    w_d.en   = wr_enbit_i;
                    w_d.base = wr_field_i;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign win_en_o[g] = w_q.en;
        assign match_o[g]  = w_q.en && ((((w_q.mask & cmp_addr_i) ^ w_q.base) & CARE) == '0);
    end

    AST_RESET_CLEARS_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_en_o == '0)); // R10

    AST_ENABLE_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(win_en_o)); // R4

endmodule

// File: rtl/pio_cmd_select.sv
module pio_cmd_select
    import pio_cls_pkg::*;
(
    input  logic [NWIN-1:0]       match_i,
    input  logic                  rd_i,
    input  logic [SIZE_W-1:0]     size_i,
    input  logic                  io_bit_i,
    input  logic [BUS_HI-BUS_LO:0] bus_i,
    output logic                  hit_o,
    output kind_e                 kind_o,
    output logic [SIZE_W-1:0]     len_o
);

    int win;

    always_comb begin
        win   = WIN_CFG;
        hit_o = |match_i;
        for (int g = 0; g < NWIN; g++) begin
            if (match_i[g]) win = g;
        end
        case (win)
            WIN_M64: kind_o = K_MEM64;
            WIN_M32: kind_o = K_MEM32;
            default: begin
                if (io_bit_i)         kind_o = K_IO;
                else if (bus_i == '0) kind_o = K_CFG0;
                else                  kind_o = K_CFG1;
            end
        endcase
    end

    always_comb begin
        if (!rd_i)                   len_o = size_i;
        else if (size_i <= MAX_RDSZ) len_o = SIZE_W'(1) << size_i[2:0];
        else                         len_o = '0;
    end

endmodule

// File: rtl/pio_region_classifier.sv
module pio_region_classifier
    import pio_cls_pkg::*;
#(
    parameter logic [3:0]  PIO_TAG   = 4'hC,
    parameter logic [7:0]  LOCAL_TAG = 8'h80,
    parameter logic [15:0] LOCAL_OFS = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld_i,
    input  logic [PKT_W-1:0]  req_pkt_i,
    output logic              cmd_vld_o,
    output logic              cmd_miss_o,
    output logic [3:0]        cmd_code_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [SIZE_W-1:0] cmd_len_o,
    output logic [TID_W-1:0]  cmd_tid_o,
    output logic [DATA_W-1:0] cmd_data_o
);

    typedef struct packed {
        logic pend;
        cmd_t cmd;
    } st_t;

    st_t st_d;
    st_t st_q;

    req_t              req;
    logic              is_pio;
    logic              is_local;
    logic [NWIN-1:0]   win_en;
    logic [NWIN-1:0]   match;
    logic              hit;
    kind_e             kind;
    logic [SIZE_W-1:0] len;
    logic              wr_en;

    pio_pkt_decode #(
        .PIO_TAG   (PIO_TAG),
        .LOCAL_TAG (LOCAL_TAG)
    ) i_decode (
        .pkt_i      (req_pkt_i),
        .req_o      (req),
        .is_pio_o   (is_pio),
        .is_local_o (is_local)
    );

    assign wr_en = st_q.pend && is_local && !req.rd;

    pio_window_bank #(
        .LOCAL_OFS (LOCAL_OFS)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_ofs_i   (req.addr[15:0]),
        .wr_enbit_i (req.data[EN_BIT]),
        .wr_field_i (req.data[CMP_HI:MEM_LO]),
        .cmp_addr_i (req.addr[CMP_HI:MEM_LO]),
        .win_en_o   (win_en),
        .match_o    (match)
    );

    pio_cmd_select i_select (
        .match_i  (match),
        .rd_i     (req.rd),
        .size_i   (req.size),
        .io_bit_i (req.addr[IO_BIT]),
        .bus_i    (req.addr[BUS_HI:BUS_LO]),
        .hit_o    (hit),
        .kind_o   (kind),
        .len_o    (len)
    );

    always_comb begin
        st_d      = '0;
        st_d.pend = req_vld_i;
        if (st_q.pend && is_pio) begin
            st_d.cmd.addr = req.addr;
            st_d.cmd.len  = len;
            st_d.cmd.tid  = req.tid;
            st_d.cmd.data = req.data;
            if (hit) begin
                st_d.cmd.vld  = 1'b1;
                st_d.cmd.code = {kind, ~req.rd};
            end else begin
                st_d.cmd.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_vld_o  = st_q.cmd.vld;
    assign cmd_miss_o = st_q.cmd.miss;
    assign cmd_code_o = st_q.cmd.code;
    assign cmd_addr_o = st_q.cmd.addr;
    assign cmd_len_o  = st_q.cmd.len;
    assign cmd_tid_o  = st_q.cmd.tid;
    assign cmd_data_o = st_q.cmd.data;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld_o && cmd_miss_o)); // R8

    AST_RESULT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o || cmd_miss_o) |-> $past(req_vld_i, 2)); // R1

    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_code_o <= 4'd9)); // R9

    AST_READ_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && !cmd_code_o[0]) |-> (($countones(cmd_len_o) <= 1) && (cmd_len_o <= 8'd16))); // R3

    AST_IO_HAS_IO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && (cmd_code_o[3:1] == 3'(K_IO))) |-> cmd_addr_o[IO_BIT]); // R6

    AST_CFG0_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && (cmd_code_o[3:1] == 3'(K_CFG0))) |-> (cmd_addr_o[BUS_HI:BUS_LO] == '0)); // R6

    AST_MEM64_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && is_pio && match[WIN_M64]) |=> (cmd_code_o[3:1] == 3'(K_MEM64))); // R7

endmodule

// File: tb/test_pio_region_classifier.sv
module test_pio_region_classifier;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_vld_i;
    logic [129:0] req_pkt_i;
    logic         cmd_vld_o;
    logic         cmd_miss_o;
    logic [3:0]   cmd_code_o;
    logic [39:0]  cmd_addr_o;
    logic [7:0]   cmd_len_o;
    logic [5:0]   cmd_tid_o;
    logic [63:0]  cmd_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pio_region_classifier i_pio_region_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld_i  (req_vld_i),
        .req_pkt_i  (req_pkt_i),
        .cmd_vld_o  (cmd_vld_o),
        .cmd_miss_o (cmd_miss_o),
        .cmd_code_o (cmd_code_o),
        .cmd_addr_o (cmd_addr_o),
        .cmd_len_o  (cmd_len_o),
        .cmd_tid_o  (cmd_tid_o),
        .cmd_data_o (cmd_data_o)
    );

    typedef struct packed {
        logic [39:0] addr;
        logic [4:0]  rq;
        logic [7:0]  size;
        logic        vld;
        logic        miss;
        logic [3:0]  code;
        logic [7:0]  len;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{40'hC0_2000_0000, 5'd0,  8'h02, 1'b1, 1'b0, 4'd0, 8'h04},
        '{40'hC0_2010_0000, 5'd1,  8'h0F, 1'b1, 1'b0, 4'd3, 8'h0F},
        '{40'hC0_3000_0000, 5'd0,  8'h00, 1'b1, 1'b0, 4'd4, 8'h01},
        '{40'hC0_3ABC_0000, 5'd4,  8'hFF, 1'b1, 1'b0, 4'd5, 8'hFF},
        '{40'hC1_0000_1234, 5'd0,  8'h04, 1'b1, 1'b0, 4'd6, 8'h10},
        '{40'hC1_7FFF_FFF8, 5'd2,  8'h3C, 1'b1, 1'b0, 4'd7, 8'h3C},
        '{40'hC1_8000_0040, 5'd0,  8'h03, 1'b1, 1'b0, 4'd8, 8'h08},
        '{40'hC1_FFFF_FFF0, 5'd31, 8'hA5, 1'b1, 1'b0, 4'd9, 8'hA5},
        '{40'hC1_0000_0000, 5'd0,  8'h05, 1'b1, 1'b0, 4'd6, 8'h00},
        '{40'hC2_0000_0000, 5'd0,  8'h01, 1'b0, 1'b1, 4'd0, 8'h02},
        '{40'hC0_4000_0000, 5'd1,  8'h11, 1'b0, 1'b1, 4'd0, 8'h11},
        '{40'hC0_21F0_0000, 5'd0,  8'h01, 1'b1, 1'b0, 4'd2, 8'h02}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [129:0] mk(input logic [4:0] rq, input logic [5:0] tid,
                                        input logic [7:0] size, input logic [39:0] addr,
                                        input logic [63:0] data);
        logic [129:0] p = '0;
        p[128:124] = rq;
        p[122:117] = tid;
        p[111:104] = size;
        p[103:64]  = addr;
        p[63:0]    = data;
        return p;
    endfunction

    // valid in one cycle, packet in the next; returns at the negedge after capture
    task automatic send(input logic [129:0] p);
        @(negedge clk);
        req_vld_i = 1'b1;
        req_pkt_i = ~p;
        @(negedge clk);
        chk("R1 no early result", {62'd0, cmd_vld_o, cmd_miss_o}, 64'd0);
        req_vld_i = 1'b0;
        req_pkt_i = p;
        @(negedge clk);
        req_pkt_i = '0;
    endtask

    task automatic quiet(input string tag);
        chk(tag, {62'd0, cmd_vld_o, cmd_miss_o}, 64'd0);
    endtask

    task automatic local_wr(input logic [15:0] ofs, input logic [63:0] d);
        send(mk(5'd1, 6'd0, 8'hFF, {8'h80, 16'h0000, ofs}, d));
        quiet("R2 local write gives no output");
    endtask

    task automatic classify(input string tag, input logic [39:0] addr, input logic [4:0] rq,
                            input logic [7:0] size, input logic exp_vld, input logic [3:0] exp_code);
        send(mk(rq, 6'h2A, size, addr, 64'h1234_5678_9ABC_DEF0));
        chk({tag, " vld"}, {63'd0, cmd_vld_o}, {63'd0, exp_vld});
        chk({tag, " miss"}, {63'd0, cmd_miss_o}, {63'd0, ~exp_vld});
        chk({tag, " code"}, {60'd0, cmd_code_o}, {60'd0, exp_code});
    endtask

    task automatic program_windows();
        local_wr(16'h2000, 64'h8000_0001_0000_0000);
        local_wr(16'h2008, 64'h0000_000F_0000_0000);
        local_wr(16'h2010, 64'h8000_0001_8000_0000);
        local_wr(16'h2018, 64'h0000_000F_8000_0000);
        local_wr(16'h2020, 64'h8000_0000_2000_0000);
        local_wr(16'h2028, 64'h0000_000F_E000_0000);
    endtask

    initial begin
        rst_n     = 1'b0;
        req_vld_i = 1'b0;
        req_pkt_i = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset vld", {63'd0, cmd_vld_o}, 64'd0);
        chk("R10 reset miss", {63'd0, cmd_miss_o}, 64'd0);
        chk("R10 reset code", {60'd0, cmd_code_o}, 64'd0);
        rst_n = 1'b1;

        // R10: all windows disabled after reset
        classify("R10 unprogrammed", 40'hC1_0000_1234, 5'd0, 8'h00, 1'b0, 4'd0);

        program_windows();

        for (int i = 0; i < NV; i++) begin
            send(mk(TBL[i].rq, 6'(i + 3), TBL[i].size, TBL[i].addr, 64'hD000_0000_0000_0000 + 64'(i)));
            chk($sformatf("R8 vec%0d vld", i), {63'd0, cmd_vld_o}, {63'd0, TBL[i].vld});
            chk($sformatf("R8 vec%0d miss", i), {63'd0, cmd_miss_o}, {63'd0, TBL[i].miss});
            chk($sformatf("R9 vec%0d code", i), {60'd0, cmd_code_o}, {60'd0, TBL[i].code});
            chk($sformatf("R3 vec%0d len", i), {56'd0, cmd_len_o}, {56'd0, TBL[i].len});
            chk($sformatf("R9 vec%0d addr", i), {24'd0, cmd_addr_o}, {24'd0, TBL[i].addr});
            chk($sformatf("R9 vec%0d tid", i), {58'd0, cmd_tid_o}, 64'(i + 3));
            chk($sformatf("R9 vec%0d data", i), cmd_data_o, 64'hD000_0000_0000_0000 + 64'(i));
            @(negedge clk);
            quiet($sformatf("R1 vec%0d one-cycle pulse", i));
        end

        // R4: local read to the 64-bit base has no effect
        send(mk(5'd0, 6'd0, 8'h00, 40'h80_0000_2010, 64'd0));
        quiet("R4 local read no output");
        classify("R4 after local read", 40'hC1_8000_0040, 5'd0, 8'h03, 1'b1, 4'd8);

        // R4: unknown local offset ignored
        local_wr(16'h2030, 64'd0);
        local_wr(16'h2004, 64'd0);
        classify("R4 after bad offset m32", 40'hC1_0000_1234, 5'd0, 8'h04, 1'b1, 4'd6);
        classify("R4 after bad offset cfg", 40'hC0_2000_0000, 5'd0, 8'h02, 1'b1, 4'd0);

        // R2: foreign register space and other routes ignored
        send(mk(5'd1, 6'd0, 8'hFF, 40'h88_0000_2010, 64'd0));
        quiet("R2 foreign space no output");
        classify("R2 after foreign write", 40'hC1_8000_0040, 5'd0, 8'h03, 1'b1, 4'd8);
        send(mk(5'd0, 6'd0, 8'h00, 40'h01_8000_0040, 64'd0));
        quiet("R2 other route no output");

        // R8: disabling the 64-bit window hands its addresses to the 32-bit one
        local_wr(16'h2010, 64'h0000_0001_8000_0000);
        classify("R8 disabled m64", 40'hC1_8000_0040, 5'd0, 8'h03, 1'b1, 4'd6);

        // R7: catch-all configuration window loses to memory windows
        local_wr(16'h2028, 64'd0);
        local_wr(16'h2020, 64'h8000_0000_0000_0000);
        classify("R7 cfg catch-all", 40'hC2_0000_0000, 5'd0, 8'h01, 1'b1, 4'd0);
        classify("R7 m32 over cfg", 40'hC1_0000_1234, 5'd1, 8'h01, 1'b1, 4'd7);
        local_wr(16'h2010, 64'h8000_0001_8000_0000);
        classify("R7 m64 over m32 and cfg", 40'hC1_8000_0040, 5'd1, 8'h01, 1'b1, 4'd9);

        // R5: mask bits cleared make those address bits don't-care
        local_wr(16'h2008, 64'h0000_0000_0000_0000);
        local_wr(16'h2000, 64'h8000_0000_0000_0000);
        classify("R5 zero mask m32", 40'hC7_0000_0000, 5'd0, 8'h00, 1'b1, 4'd6);

        // R10: reset in mid-run clears windows
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        quiet("R10 outputs low after reset");
        classify("R10 windows cleared", 40'hC1_8000_0040, 5'd0, 8'h03, 1'b0, 4'd0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule